// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Registers

This block keeps the four shared resource registers that an isochronous resource manager offers to every node on a serial bus. They are the bus-manager identity, the remaining isochronous bandwidth, and two 32-bit channel allocation masks. Each request arrives on one cycle as a quadlet read, write or lock, with an address, a length, a data value, an argument value and an extended lock code. One cycle later the block returns a response code and a value.

The lock requests apply a compare-swap rule that differs for each resource. For bandwidth, the argument/data pair is read as an allocation or a release, and each is range checked. For channels, only the bits that the request toggles are compared. For the bus-manager identity, the rule is a plain compare-swap. Channel 31, the broadcast channel, stays reserved no matter what a request carries. A single-cycle bus-reset pulse puts all four registers back to their power-up values.

Top module: `irm_lock_regs`

## Requirements
- R1: On `rst`, and in the cycle after any `bus_reset` pulse, the bus-manager register holds 0x3F, bandwidth holds 4915, channels-high holds 0xFFFFFFFE and channels-low holds 0xFFFFFFFF.
- R2: Every accepted request (`req_valid` high) produces exactly one `rsp_valid` pulse on the next cycle. A read of a mapped register returns code 0 (complete) with that register's current value.
- R3: Bit 0 of channels-high, which stands for channel 31, is always 0. Before any channels-high lock is evaluated, bit 0 of its data is cleared.
- R4: A lock whose extended code is not 2 (compare-swap) to a mapped register returns code 1 (type error) and changes nothing. Kind 3 also returns a type error.
- R5: A write (kind 1) to any of the four registers returns a type error and changes nothing.
- R6: In a bandwidth lock with arg > data, the amount is arg−data. If the register is at least that amount, it is reduced by it and arg is returned. Otherwise the old value is returned and the register is unchanged.
- R7: In a bandwidth lock with data > arg, the amount is data−arg. The register is increased by that amount only if the result stays below 0x2000, and then arg is returned. Otherwise the old value is returned.
- R8: A bandwidth lock with data equal to arg returns the old value and leaves the register unchanged.
- R9: A channel lock uses the mask arg XOR data. If the register matches arg on every masked bit, the register is XORed with the mask and arg is returned. Otherwise the current value is returned and the register is unchanged.
- R10: A bus-manager lock always returns the old value, and stores data only when the old value equals arg.
- R11: An address whose low two bits are not zero, or a length other than 4 bytes, returns a type error with value 0. This check comes before the address-range check.
- R12: An address outside the four quadlets starting at `REG_BASE` (bus-manager, bandwidth, channels-high and channels-low, in that order) returns code 2 (address error) with value 0.
- R13: When `bus_reset` coincides with a lock, the response carries the lock's result computed from the pre-reset state, and the registers take their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle bus-reset pulse; reinitialises the registers |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 lock, 3 reserved |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | LEN_W | Request length in bytes |
| req_data | input | DATA_W | Data value (new value for a lock) |
| req_arg | input | DATA_W | Argument value (expected value for a lock) |
| req_ext | input | EXT_W | Extended lock code; 2 is compare-swap |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_value | output | DATA_W | Returned value; 0 on error |

## Verification
Two functions can land in the same edge: a bus-reset pulse and a lock request that would change a register. The bench drives both together on purpose, against a register that the lock would otherwise update. It then checks two things: the response still holds the lock's result taken from the pre-reset state, and a following read shows the reset value rather than the locked one. Random traffic also raises `bus_reset` on roughly one request in forty, so the same collision also occurs with reads, writes and errored requests.

// File: rtl/irm_pkg.sv
package irm_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_LOCK  = 2'd2,
    KIND_RSVD  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    RSP_DONE     = 2'd0,
    RSP_TYPE_ERR = 2'd1,
    RSP_ADDR_ERR = 2'd2
  } rsp_code_e;

  typedef enum logic [1:0] {
    SEL_BMGR    = 2'd0,
    SEL_BWIDTH  = 2'd1,
    SEL_CHAN_HI = 2'd2,
    SEL_CHAN_LO = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irm_decode.sv
module irm_decode
  import irm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LEN_W      = 4,
  parameter int EXT_W      = 4,
  parameter int REG_BASE   = 'h21C,
  parameter int CSWAP_CODE = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  req_kind_e         kind,
  input  logic [EXT_W-1:0]  ext,
  output reg_sel_e          sel,
  output rsp_code_e         code,
  output logic              do_lock
);
  localparam int MAP_BYTES = 16;

  logic [ADDR_W-1:0] off;
  logic hit, aligned, is_cswap;

  always_comb begin
    off      = addr - ADDR_W'(REG_BASE);
    hit      = off < ADDR_W'(MAP_BYTES);
    aligned  = (addr[1:0] == 2'b00) && (len == LEN_W'(4));
    is_cswap = ext == EXT_W'(CSWAP_CODE);
    sel      = reg_sel_e'(off[3:2]);
    if (!aligned)      code = RSP_TYPE_ERR;
    else if (!hit)     code = RSP_ADDR_ERR;
    else begin
      unique case (kind)
        KIND_READ: code = RSP_DONE;
        KIND_LOCK: code = is_cswap ? RSP_DONE : RSP_TYPE_ERR;
        default:   code = RSP_TYPE_ERR;
      endcase
    end
    do_lock = aligned && hit && (kind == KIND_LOCK) && is_cswap;
  end
endmodule

// File: rtl/irm_bw_lock.sv
module irm_bw_lock #(
  parameter int DATA_W   = 32,
  parameter int BW_LIMIT = 'h2000
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] arg,
  output logic [DATA_W-1:0] nxt,
  output logic [DATA_W-1:0] ret,
  output logic              upd
);
  logic [DATA_W-1:0] amt;
  logic [DATA_W:0]   sum;

  always_comb begin
    nxt = cur;
    ret = cur;
    upd = 1'b0;
    amt = '0;
    sum = '0;
    if (arg > data) begin
      amt = arg - data;
      if (cur >= amt) begin
        nxt = cur - amt;
        ret = arg;
        upd = 1'b1;
      end
    end else if (data > arg) begin
      amt = data - arg;
      sum = {1'b0, cur} + {1'b0, amt};
      if (sum < (DATA_W+1)'(BW_LIMIT)) begin
        nxt = sum[DATA_W-1:0];
        ret = arg;
        upd = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irm_chan_lock.sv
module irm_chan_lock #(
  parameter int DATA_W      = 32,
  parameter bit KEEP_LSB_LO = 1'b0
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] arg,
  output logic [DATA_W-1:0] nxt,
  output logic [DATA_W-1:0] ret,
  output logic              upd
);
  logic [DATA_W-1:0] dat_f, mask;

  generate
    if (KEEP_LSB_LO) begin : g_keep
      assign dat_f = {data[DATA_W-1:1], 1'b0};
    end else begin : g_pass
      assign dat_f = data;
    end
  endgenerate

  always_comb begin
    mask = arg ^ dat_f;
    if ((arg & mask) == (cur & mask)) begin
      nxt = cur ^ mask;
      ret = arg;
      upd = 1'b1;
    end else begin
      nxt = cur;
      ret = cur;
      upd = 1'b0;
    end
  end
endmodule

// File: rtl/irm_lock_regs.sv
module irm_lock_regs
  import irm_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 12,
  parameter int              LEN_W      = 4,
  parameter int              EXT_W      = 4,
  parameter int              REG_BASE   = 'h21C,
  parameter int              CSWAP_CODE = 2,
  parameter int              BW_LIMIT   = 'h2000,
  parameter logic [DATA_W-1:0] BM_INIT  = 'h3F,
  parameter logic [DATA_W-1:0] BW_INIT  = 4915,
  parameter logic [DATA_W-1:0] CHI_INIT = 'hFFFF_FFFE,
  parameter logic [DATA_W-1:0] CLO_INIT = 'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] req_arg,
  input  logic [EXT_W-1:0]  req_ext,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_value
);
  localparam int N_CHAN = 2;

  logic [DATA_W-1:0] bm_q, bw_q;
  logic [DATA_W-1:0] chan_q [N_CHAN];

  req_kind_e kind;
  reg_sel_e  sel;
  rsp_code_e code;
  logic      do_lock;

  assign kind = req_kind_e'(req_kind);

  irm_decode #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .EXT_W(EXT_W),
    .REG_BASE(REG_BASE), .CSWAP_CODE(CSWAP_CODE)
  ) u_dec (
    .addr(req_addr), .len(req_len), .kind(kind), .ext(req_ext),
    .sel(sel), .code(code), .do_lock(do_lock)
  );

  logic [DATA_W-1:0] bw_nxt, bw_ret;
  logic              bw_upd;

  irm_bw_lock #(.DATA_W(DATA_W), .BW_LIMIT(BW_LIMIT)) u_bw (
    .cur(bw_q), .data(req_data), .arg(req_arg),
    .nxt(bw_nxt), .ret(bw_ret), .upd(bw_upd)
  );

  logic [DATA_W-1:0] ch_nxt [N_CHAN];
  logic [DATA_W-1:0] ch_ret [N_CHAN];
  logic              ch_upd [N_CHAN];

  generate
    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
      irm_chan_lock #(.DATA_W(DATA_W), .KEEP_LSB_LO(i == 0)) u_ch (
        .cur(chan_q[i]), .data(req_data), .arg(req_arg),
        .nxt(ch_nxt[i]), .ret(ch_ret[i]), .upd(ch_upd[i])
      );
    end
  endgenerate

  logic [DATA_W-1:0] cur_val, lock_val, out_val;

  always_comb begin
    unique case (sel)
      SEL_BMGR:    begin cur_val = bm_q;      lock_val = bm_q;      end
      SEL_BWIDTH:  begin cur_val = bw_q;      lock_val = bw_ret;    end
      SEL_CHAN_HI: begin cur_val = chan_q[0]; lock_val = ch_ret[0]; end
      default:     begin cur_val = chan_q[1]; lock_val = ch_ret[1]; end
    endcase
    if (code != RSP_DONE)        out_val = '0;
    else if (kind == KIND_READ)  out_val = cur_val;
    else                         out_val = lock_val;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      bm_q      <= BM_INIT;
      bw_q      <= BW_INIT;
      chan_q[0] <= CHI_INIT;
      chan_q[1] <= CLO_INIT;
    end else if (req_valid && do_lock) begin
      unique case (sel)
        SEL_BMGR:    if (bm_q == req_arg) bm_q <= req_data;
        SEL_BWIDTH:  if (bw_upd)    bw_q      <= bw_nxt;
        SEL_CHAN_HI: if (ch_upd[0]) chan_q[0] <= ch_nxt[0];
        default:     if (ch_upd[1]) chan_q[1] <= ch_nxt[1];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_DONE;
      rsp_value <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= code;
      rsp_value <= out_val;
    end
  end
endmodule

// File: rtl/irm_lock_regs_chk.sv
module irm_lock_regs_chk #(
  parameter int                DATA_W   = 32,
  parameter int                BW_LIMIT = 'h2000,
  parameter logic [DATA_W-1:0] BM_INIT  = 'h3F,
  parameter logic [DATA_W-1:0] BW_INIT  = 4915,
  parameter logic [DATA_W-1:0] CHI_INIT = 'hFFFF_FFFE,
  parameter logic [DATA_W-1:0] CLO_INIT = 'hFFFF_FFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_reset,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [DATA_W-1:0] rsp_value,
  input logic [DATA_W-1:0] bm_q,
  input logic [DATA_W-1:0] bw_q,
  input logic [DATA_W-1:0] chan_hi,
  input logic [DATA_W-1:0] chan_lo
);
  AST_CH31_HELD: assert property (@(posedge clk) disable iff (rst)
    chan_hi[0] == 1'b0);  // R3

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);  // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);  // R2

  AST_BUS_RESET_INIT: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (bm_q == BM_INIT) && (bw_q == BW_INIT) &&
                  (chan_hi == CHI_INIT) && (chan_lo == CLO_INIT));  // R1

  AST_BW_BOUND: assert property (@(posedge clk) disable iff (rst)
    bw_q < DATA_W'(BW_LIMIT));  // R7

  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1 && !bus_reset) |=>
      ($stable(bm_q) && $stable(bw_q) && $stable(chan_hi) && $stable(chan_lo)));  // R5

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_value == '0));  // R11
endmodule

bind irm_lock_regs irm_lock_regs_chk #(
  .DATA_W(DATA_W), .BW_LIMIT(BW_LIMIT), .BM_INIT(BM_INIT),
  .BW_INIT(BW_INIT), .CHI_INIT(CHI_INIT), .CLO_INIT(CLO_INIT)
) u_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .req_valid(req_valid),
  .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rsp_value(rsp_value), .bm_q(bm_q), .bw_q(bw_q),
  .chan_hi(chan_q[0]), .chan_lo(chan_q[1])
);

// File: tb/test_irm_lock_regs.sv
`timescale 1ns/1ps
module test_irm_lock_regs;
  localparam int BASE = 'h21C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [31:0] req_data = '0, req_arg = '0;
  logic [3:0]  req_ext = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_value;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_reg [4];

  always #4 clk = ~clk;

  irm_lock_regs i_irm_lock_regs (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
    .req_data(req_data), .req_arg(req_arg), .req_ext(req_ext),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_value(rsp_value)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    m_reg[0] = 32'h3F; m_reg[1] = 32'd4915;
    m_reg[2] = 32'hFFFF_FFFE; m_reg[3] = 32'hFFFF_FFFF;
  endtask

  task automatic model(input logic [1:0] k, input logic [11:0] a, input logic [3:0] l,
                       input logic [31:0] d, input logic [31:0] g, input logic [3:0] e,
                       output logic [1:0] code, output logic [31:0] val);
    logic [11:0] off;
    logic [31:0] dd, msk;
    int idx;
    off = a - 12'(BASE);
    code = 2'd0; val = 32'd0;
    if (a[1:0] != 2'b00 || l != 4'd4) code = 2'd1;            // R11
    else if (off >= 12'd16) code = 2'd2;                      // R12
    else begin
      idx = int'(off[3:2]);
      if (k == 2'd0) val = m_reg[idx];                        // R2
      else if (k != 2'd2 || e != 4'd2) code = 2'd1;           // R4 R5
      else if (idx == 0) begin                                // R10
        val = m_reg[0];
        if (m_reg[0] == g) m_reg[0] = d;
      end else if (idx == 1) begin
        val = m_reg[1];
        if (g > d) begin                                      // R6
          if (m_reg[1] >= g - d) begin m_reg[1] = m_reg[1] - (g - d); val = g; end
        end else if (d > g) begin                             // R7
          if ({1'b0, m_reg[1]} + {1'b0, d - g} < 33'h2000) begin
            m_reg[1] = m_reg[1] + (d - g); val = g;
          end
        end                                                   // R8 equal: old value
      end else begin                                          // R9 R3
        dd = (idx == 2) ? (d & 32'hFFFF_FFFE) : d;
        msk = g ^ dd;
        if ((g & msk) == (m_reg[idx] & msk)) begin m_reg[idx] = m_reg[idx] ^ msk; val = g; end
        else val = m_reg[idx];
      end
    end
  endtask

  task automatic do_req(input logic [1:0] k, input logic [11:0] a, input logic [3:0] l,
                        input logic [31:0] d, input logic [31:0] g, input logic [3:0] e,
                        input bit brst, input string tag);
    logic [1:0] ecode;
    logic [31:0] eval;
    model(k, a, l, d, g, e, ecode, eval);
    if (brst) model_init();                                   // R13
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = l;
    req_data = d; req_arg = g; req_ext = e; bus_reset = brst;
    @(negedge clk);
    chk(rsp_valid == 1'b1, {tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_code == ecode, {tag, " code"}, 32'(rsp_code), 32'(ecode));
    chk(rsp_value == eval, {tag, " value"}, rsp_value, eval);
    req_valid = 1'b0; bus_reset = 1'b0;
  endtask

  task automatic rd(input int idx, input string tag);
    do_req(2'd0, 12'(BASE + 4*idx), 4'd4, 32'd0, 32'd0, 4'd2, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_init();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle after reset", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < 4; i++) rd(i, "R1 reset value");

    // bandwidth
    do_req(2'd2, 12'(BASE+4), 4'd4, 32'd4815, 32'd4915, 4'd2, 1'b0, "R6 allocate ok");
    do_req(2'd2, 12'(BASE+4), 4'd4, 32'd0, 32'd5000, 4'd2, 1'b0, "R6 allocate too big");
    do_req(2'd2, 12'(BASE+4), 4'd4, 32'd7, 32'd7, 4'd2, 1'b0, "R8 equal");
    do_req(2'd2, 12'(BASE+4), 4'd4, 32'd4000, 32'd0, 4'd2, 1'b0, "R7 release overflow");
    do_req(2'd2, 12'(BASE+4), 4'd4, 32'd3376, 32'd0, 4'd2, 1'b0, "R7 release to 0x1FFF");
    do_req(2'd2, 12'(BASE+4), 4'd4, 32'd1, 32'd0, 4'd2, 1'b0, "R7 release at limit");
    rd(1, "R7 readback");
    // channels
    do_req(2'd2, 12'(BASE+8), 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 4'd2, 1'b0, "R3 set ch31 masked");
    do_req(2'd2, 12'(BASE+8), 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd2, 1'b0, "R3 ch31 compare");
    rd(2, "R3 readback");
    do_req(2'd2, 12'(BASE+12), 4'd4, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 4'd2, 1'b0, "R9 alloc ok");
    do_req(2'd2, 12'(BASE+12), 4'd4, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 4'd2, 1'b0, "R9 alloc clash");
    rd(3, "R9 readback");
    // bus manager
    do_req(2'd2, 12'(BASE), 4'd4, 32'd5, 32'h3F, 4'd2, 1'b0, "R10 swap ok");
    do_req(2'd2, 12'(BASE), 4'd4, 32'd9, 32'h3F, 4'd2, 1'b0, "R10 swap miss");
    rd(0, "R10 readback");
    // errors
    do_req(2'd1, 12'(BASE+4), 4'd4, 32'd1, 32'd0, 4'd2, 1'b0, "R5 write");
    rd(1, "R5 readback");
    do_req(2'd2, 12'(BASE), 4'd4, 32'd1, 32'd5, 4'd1, 1'b0, "R4 non cswap");
    do_req(2'd3, 12'(BASE), 4'd4, 32'd1, 32'd5, 4'd2, 1'b0, "R4 reserved kind");
    rd(0, "R4 readback");
    do_req(2'd0, 12'(BASE+2), 4'd4, 32'd0, 32'd0, 4'd2, 1'b0, "R11 misaligned");
    do_req(2'd0, 12'(BASE+4), 4'd8, 32'd0, 32'd0, 4'd2, 1'b0, "R11 length");
    do_req(2'd0, 12'(BASE+16), 4'd4, 32'd0, 32'd0, 4'd2, 1'b0, "R12 above map");
    do_req(2'd2, 12'(BASE-4), 4'd4, 32'd0, 32'd0, 4'd2, 1'b0, "R12 below map");
    // collision
    do_req(2'd2, 12'(BASE), 4'd4, 32'd9, 32'd5, 4'd2, 1'b1, "R13 lock with bus reset");
    rd(0, "R13 readback");
    rd(1, "R1 bus reset bw");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int sel, idx;
      logic [11:0] a;
      logic [3:0] l, e;
      logic [1:0] k;
      logic [31:0] d, g;
      sel = int'($urandom_range(0, 9));
      idx = int'($urandom_range(0, 3));
      a = (sel == 8) ? 12'(BASE + 16 + 4*idx) : (sel == 9) ? 12'(BASE + 4*idx + 1) : 12'(BASE + 4*idx);
      l = ($urandom_range(0, 15) == 0) ? 4'd8 : 4'd4;
      k = ($urandom_range(0, 4) < 3) ? 2'd2 : 2'($urandom_range(0, 3));
      e = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'd2;
      if (idx == 1) begin
        g = ($urandom_range(0, 1) == 1) ? m_reg[1] : 32'($urandom_range(0, 8191));
        d = 32'($urandom_range(0, 8191));
      end else if (idx == 0) begin
        g = ($urandom_range(0, 1) == 1) ? m_reg[0] : 32'($urandom_range(0, 63));
        d = 32'($urandom_range(0, 63));
      end else begin
        g = ($urandom_range(0, 2) != 0) ? m_reg[idx] : $urandom();
        d = g ^ (32'd1 << $urandom_range(0, 31)) ^ (($urandom_range(0, 3) == 0) ? 32'd1 : 32'd0);
      end
      do_req(k, a, l, d, g, e, $urandom_range(0, 39) == 0, "R2 R6 R7 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule